// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is the host side of a pin-level parallel programming link to a flash target. It runs one of two jobs: a whole-chip erase, or a single page write. For a page write the caller gives a page number. The caller then offers 16-bit words through a valid/ready handshake, and the sequencer pulls one word at a time. It drives the target's mode-select pair, byte-select line, 8-bit data bus and three strobes: load, page latch and an active-low write. It then waits on the target's ready/busy input before it reports completion.

Every target action is one strobe step, and each step has three phases. First the lines settle with no strobe active. Then the strobe is active for `PULSE_CYC` clocks. Then the lines are held for one clock with the strobe inactive. A page write issues the command byte, then four steps per word, then the upper address byte and a write pulse. The word loop ends when the page is full or when the caller marks a word as the last one. A timeout counter guards the final wait on the target.

Top module: `pp_seq`

## Requirements
- R1: After reset the block drives mode 2'b00, byte-select 0, bus 8'h00, load 0, latch 0 and write 1 (inactive), with busy, done, tmo_err and word_ready all 0.
- R2: A chip erase sends a load with mode 2'b10, byte-select 0 and bus 8'h80. It then sends a write pulse (pin_wr_n low) with those same lines, then waits for pin_rdy high.
- R3: A page write first sends a load with mode 2'b10, byte-select 0 and bus 8'h10.
- R4: For each accepted word, four steps run in this order: a load with mode 2'b00 and byte-select 0 carrying the address low byte; a load with mode 2'b01 and byte-select 0 carrying data bits [7:0]; a load with mode 2'b01 and byte-select 1 carrying data bits [15:8]; and a latch pulse with mode 2'b01, byte-select 1 and the bus still carrying data bits [15:8].
- R5: The word address is {page_num, word index} with a word index of log2(WPP) bits, zero-extended to 16 bits. Its bits [7:0] form the address low byte, so the low page bits land in that byte. After the last word, a load with mode 2'b00, byte-select 1 and address bits [15:8] is sent. A write pulse follows on the same lines.
- R6: The word loop ends after WPP words or after a word accepted with word_last=1, whichever comes first. No further word is taken.
- R7: Only one strobe is active at a time. Each strobe is active for exactly PULSE_CYC clocks. Mode, byte-select and bus are stable for at least one clock before a strobe becomes active, and for one clock after it ends.
- R8: A request is accepted only while pin_rdy is 1. While pin_rdy is 0 an idle block ignores requests: no strobe is issued and busy stays 0.
- R9: When erase_req and write_req are both high at acceptance, the erase runs.
- R10: If pin_rdy stays 0 for TMO_CYC consecutive clocks in the final wait, tmo_err is set and the block returns to idle without done. tmo_err stays set until the next request is accepted.
- R11: word_ready is 1 only while the block waits for a word, and it is then the only activity: no strobe is active. Holding word_valid low stalls the sequence.
- R12: busy is 1 from the clock after acceptance until completion. done is a single-clock pulse, given the clock after pin_rdy is seen high in the final wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| erase_req | input | 1 | Request a chip erase |
| write_req | input | 1 | Request a page write |
| page_num | input | PAGE_W | Page number, captured at acceptance |
| word_data | input | 16 | Word offered to the sequencer |
| word_last | input | 1 | Offered word is the final one of the page |
| word_valid | input | 1 | Offered word is valid |
| word_ready | output | 1 | Sequencer takes the offered word this clock |
| pin_mode | output | 2 | Mode-select pair to the target |
| pin_bsel | output | 1 | Byte-select line to the target |
| pin_bus | output | 8 | Data bus to the target |
| pin_load | output | 1 | Load strobe, active high |
| pin_latch | output | 1 | Page-latch strobe, active high |
| pin_wr_n | output | 1 | Write strobe, active low |
| pin_rdy | input | 1 | Target ready (1) / busy (0) |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-clock pulse when a job completes |
| tmo_err | output | 1 | Target stayed busy past the timeout |

## Verification
The timeout exit is the hardest case to reach from the ports. It needs the target to drop ready/busy at the write pulse and never raise it again, while an ordinary job must still see the target recover well inside the limit. The bench's target model therefore pins ready low once it sees the write strobe in that one test. It then lets ready recover and runs a normal erase, which shows that the error holds until the next accepted request and then clears. The request-ignored case uses the same model to hold ready low from idle while both requests are raised.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_GETW, ST_ALO, ST_DLO,
        ST_DHI, ST_LATCH, ST_AHI, ST_WR, ST_WAIT
    } st_e;

    typedef enum logic [1:0] {PH_SET, PH_PULSE, PH_HOLD} ph_e;

    localparam logic [1:0] MODE_ADDR = 2'b00;
    localparam logic [1:0] MODE_DATA = 2'b01;
    localparam logic [1:0] MODE_CMD  = 2'b10;
    localparam logic [7:0] OPC_ERASE = 8'h80;
    localparam logic [7:0] OPC_PAGE  = 8'h10;

    typedef struct packed {
        logic [1:0] mode;
        logic       bsel;
        logic [7:0] bus;
        logic       load;
        logic       latch;
        logic       wr_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{mode: 2'b00, bsel: 1'b0, bus: 8'h00,
                                    load: 1'b0, latch: 1'b0, wr_n: 1'b1};

endpackage

// File: rtl/pp_addr_join.sv
`timescale 1ns/1ps
module pp_addr_join #(
    parameter int PAGE_W = 12,
    parameter int IDX_W  = 4
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [IDX_W-1:0]  idx,
    output logic [7:0]        lo,
    output logic [7:0]        hi
);
    localparam int JW = PAGE_W + IDX_W;

    logic [JW-1:0] joined;
    logic [15:0]   full;

    assign joined = {page, idx};

    generate
        if (JW >= 16) begin : g_trim
            assign full = joined[15:0];
        end else begin : g_pad
            assign full = {{(16-JW){1'b0}}, joined};
        end
    endgenerate

    assign lo = full[7:0];
    assign hi = full[15:8];
endmodule

// File: rtl/pp_rdy_timer.sv
`timescale 1ns/1ps
module pp_rdy_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(LIMIT)) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pp_pin_map.sv
`timescale 1ns/1ps
module pp_pin_map
    import pp_pkg::*;
(
    input  st_e         st,
    input  ph_e         ph,
    input  logic        erase,
    input  logic [15:0] word,
    input  logic [7:0]  a_lo,
    input  logic [7:0]  a_hi,
    output pins_t       pins
);
    logic on;

    always_comb begin
        on   = (ph == PH_PULSE);
        pins = PINS_IDLE;
        unique case (st)
            ST_CMD: begin
                pins.mode = MODE_CMD;
                pins.bsel = 1'b0;
                pins.bus  = erase ? OPC_ERASE : OPC_PAGE;
                pins.load = on;
            end
            ST_ALO: begin
                pins.mode = MODE_ADDR;
                pins.bsel = 1'b0;
                pins.bus  = a_lo;
                pins.load = on;
            end
            ST_DLO: begin
                pins.mode = MODE_DATA;
                pins.bsel = 1'b0;
                pins.bus  = word[7:0];
                pins.load = on;
            end
            ST_DHI: begin
                pins.mode = MODE_DATA;
                pins.bsel = 1'b1;
                pins.bus  = word[15:8];
                pins.load = on;
            end
            ST_LATCH: begin
                pins.mode  = MODE_DATA;
                pins.bsel  = 1'b1;
                pins.bus   = word[15:8];
                pins.latch = on;
            end
            ST_AHI: begin
                pins.mode = MODE_ADDR;
                pins.bsel = 1'b1;
                pins.bus  = a_hi;
                pins.load = on;
            end
            ST_WR: begin
                if (erase) begin
                    pins.mode = MODE_CMD;
                    pins.bsel = 1'b0;
                    pins.bus  = OPC_ERASE;
                end else begin
                    pins.mode = MODE_ADDR;
                    pins.bsel = 1'b1;
                    pins.bus  = a_hi;
                end
                pins.wr_n = ~on;
            end
            default: pins = PINS_IDLE;
        endcase
    end
endmodule

// File: rtl/pp_seq.sv
`timescale 1ns/1ps
module pp_seq
    import pp_pkg::*;
#(
    parameter int WPP       = 16,
    parameter int PAGE_W    = 12,
    parameter int PULSE_CYC = 2,
    parameter int TMO_CYC   = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic              write_req,
    input  logic [PAGE_W-1:0] page_num,
    input  logic [15:0]       word_data,
    input  logic              word_last,
    input  logic              word_valid,
    output logic              word_ready,
    output logic [1:0]        pin_mode,
    output logic              pin_bsel,
    output logic [7:0]        pin_bus,
    output logic              pin_load,
    output logic              pin_latch,
    output logic              pin_wr_n,
    input  logic              pin_rdy,
    output logic              busy,
    output logic              done,
    output logic              tmo_err
);
    localparam int IDX_W  = $clog2(WPP);
    localparam int PCNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic [PCNT_W-1:0] cnt;
        logic [IDX_W-1:0]  idx;
        logic [PAGE_W-1:0] page;
        logic [15:0]       word;
        logic              last;
        logic              erase;
        logic              busy;
        logic              done;
        logic              err;
    } ctx_t;

    ctx_t  ctx_d, ctx_q;
    pins_t pins_d, pins_q;
    logic [7:0] a_lo, a_hi;
    logic wait_run, tmo_hit, step_end, in_step;

    pp_addr_join #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_addr (
        .page(ctx_q.page), .idx(ctx_q.idx), .lo(a_lo), .hi(a_hi)
    );

    assign wait_run = (ctx_q.st == ST_WAIT) && !pin_rdy;

    pp_rdy_timer #(.LIMIT(TMO_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .hit(tmo_hit)
    );

    pp_pin_map u_map (
        .st(ctx_d.st), .ph(ctx_d.ph), .erase(ctx_d.erase), .word(ctx_d.word),
        .a_lo(a_lo), .a_hi(a_hi), .pins(pins_d)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        step_end   = 1'b0;
        in_step    = ctx_q.st inside {ST_CMD, ST_ALO, ST_DLO, ST_DHI,
                                      ST_LATCH, ST_AHI, ST_WR};
        // shared three-phase timing of every strobe step
        if (in_step) begin
            unique case (ctx_q.ph)
                PH_SET: begin
                    ctx_d.ph  = PH_PULSE;
                    ctx_d.cnt = '0;
                end
                PH_PULSE: begin
                    if (ctx_q.cnt == PCNT_W'(PULSE_CYC - 1)) ctx_d.ph = PH_HOLD;
                    else ctx_d.cnt = ctx_q.cnt + 1'b1;
                end
                default: begin
                    step_end = 1'b1;
                    ctx_d.ph = PH_SET;
                end
            endcase
        end

        unique case (ctx_q.st)
            ST_IDLE: begin
                if (pin_rdy && (erase_req || write_req)) begin
                    ctx_d.st    = ST_CMD;
                    ctx_d.ph    = PH_SET;
                    ctx_d.erase = erase_req;
                    ctx_d.page  = page_num;
                    ctx_d.idx   = '0;
                    ctx_d.busy  = 1'b1;
                    ctx_d.err   = 1'b0;
                end
            end
            ST_CMD:   if (step_end) ctx_d.st = ctx_q.erase ? ST_WR : ST_GETW;
            ST_GETW: begin
                if (word_valid) begin
                    ctx_d.word = word_data;
                    ctx_d.last = word_last;
                    ctx_d.st   = ST_ALO;
                    ctx_d.ph   = PH_SET;
                end
            end
            ST_ALO:   if (step_end) ctx_d.st = ST_DLO;
            ST_DLO:   if (step_end) ctx_d.st = ST_DHI;
            ST_DHI:   if (step_end) ctx_d.st = ST_LATCH;
            ST_LATCH: begin
                if (step_end) begin
                    if (ctx_q.last || (ctx_q.idx == IDX_W'(WPP - 1))) begin
                        ctx_d.st = ST_AHI;
                    end else begin
                        ctx_d.st  = ST_GETW;
                        ctx_d.idx = ctx_q.idx + 1'b1;
                    end
                end
            end
            ST_AHI:   if (step_end) ctx_d.st = ST_WR;
            ST_WR:    if (step_end) ctx_d.st = ST_WAIT;
            ST_WAIT: begin
                if (pin_rdy) begin
                    ctx_d.st   = ST_IDLE;
                    ctx_d.busy = 1'b0;
                    ctx_d.done = 1'b1;
                end else if (tmo_hit) begin
                    ctx_d.st   = ST_IDLE;
                    ctx_d.busy = 1'b0;
                    ctx_d.err  = 1'b1;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q  <= '0;
            pins_q <= PINS_IDLE;
        end else begin
            ctx_q  <= ctx_d;
            pins_q <= pins_d;
        end
    end

    assign word_ready = (ctx_q.st == ST_GETW);
    assign pin_mode   = pins_q.mode;
    assign pin_bsel   = pins_q.bsel;
    assign pin_bus    = pins_q.bus;
    assign pin_load   = pins_q.load;
    assign pin_latch  = pins_q.latch;
    assign pin_wr_n   = pins_q.wr_n;
    assign busy       = ctx_q.busy;
    assign done       = ctx_q.done;
    assign tmo_err    = ctx_q.err;
endmodule

// File: rtl/pp_seq_chk.sv
`timescale 1ns/1ps
module pp_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] pin_mode,
    input logic       pin_bsel,
    input logic [7:0] pin_bus,
    input logic       pin_load,
    input logic       pin_latch,
    input logic       pin_wr_n,
    input logic       pin_rdy,
    input logic       word_ready,
    input logic       busy,
    input logic       done,
    input logic       tmo_err
);
    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pin_load, pin_latch, !pin_wr_n}));

    // R7
    load_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_load) |-> ($stable(pin_mode) && $stable(pin_bsel) && $stable(pin_bus)));

    // R7
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_load) |-> ($stable(pin_mode) && $stable(pin_bsel) && $stable(pin_bus)));

    // R7
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_wr_n) |-> ($stable(pin_mode) && $stable(pin_bsel) && $stable(pin_bus)));

    // R8
    accept_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pin_rdy));

    // R12
    done_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(pin_rdy) && !busy));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> (busy && !pin_load && !pin_latch && pin_wr_n));

    // R10
    tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> (!busy && !done));
endmodule

bind pp_seq pp_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .pin_bsel(pin_bsel),
    .pin_bus(pin_bus), .pin_load(pin_load), .pin_latch(pin_latch),
    .pin_wr_n(pin_wr_n), .pin_rdy(pin_rdy), .word_ready(word_ready),
    .busy(busy), .done(done), .tmo_err(tmo_err)
);

// File: tb/sim_pp_seq.sv
`timescale 1ns/1ps
module sim_pp_seq;
    localparam int WPP    = 16;
    localparam int PAGE_W = 12;
    localparam int PW     = 2;
    localparam int TMO    = 64;
    localparam int BUSY_N = 20;

    // vector: erase, both, page, nwords, seed, gap, spare
    localparam logic [39:0] VEC [6] = '{
        {1'b1, 1'b0, 12'h000, 5'd0,  16'h0000, 4'd0, 1'b0},
        {1'b0, 1'b0, 12'h000, 5'd16, 16'hA5A5, 4'd0, 1'b0},
        {1'b0, 1'b0, 12'hFFF, 5'd16, 16'h0001, 4'd2, 1'b0},
        {1'b0, 1'b0, 12'h123, 5'd3,  16'hBEEF, 4'd1, 1'b0},
        {1'b0, 1'b0, 12'h05A, 5'd1,  16'h0000, 4'd0, 1'b0},
        {1'b1, 1'b1, 12'h777, 5'd0,  16'h1234, 4'd0, 1'b0}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              erase_req = 1'b0, write_req = 1'b0;
    logic [PAGE_W-1:0] page_num = '0;
    logic [15:0]       word_data = '0;
    logic              word_last = 1'b0, word_valid = 1'b0;
    logic              word_ready;
    logic [1:0]        pin_mode;
    logic              pin_bsel;
    logic [7:0]        pin_bus;
    logic              pin_load, pin_latch, pin_wr_n;
    logic              rdy_m = 1'b1;
    logic              busy, done, tmo_err;

    pp_seq #(.WPP(WPP), .PAGE_W(PAGE_W), .PULSE_CYC(PW), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .write_req(write_req),
        .page_num(page_num), .word_data(word_data), .word_last(word_last),
        .word_valid(word_valid), .word_ready(word_ready), .pin_mode(pin_mode),
        .pin_bsel(pin_bsel), .pin_bus(pin_bus), .pin_load(pin_load),
        .pin_latch(pin_latch), .pin_wr_n(pin_wr_n), .pin_rdy(rdy_m),
        .busy(busy), .done(done), .tmo_err(tmo_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // target model: busy after a write pulse, or held low on demand
    logic hold_low = 1'b0;
    int   bcnt = 0;
    always @(negedge clk) begin
        if (hold_low) rdy_m <= 1'b0;
        else if (!pin_wr_n) begin
            rdy_m <= 1'b0;
            bcnt  <= BUSY_N;
        end else if (bcnt != 0) bcnt <= bcnt - 1;
        else rdy_m <= 1'b1;
    end

    // pin monitor: event log plus timing checks
    logic [12:0] ev [256];
    int          ev_n = 0;
    logic [1:0]  p_mode = 2'b00;
    logic        p_bsel = 1'b0;
    logic [7:0]  p_bus = 8'h00;
    logic        p_load = 1'b0, p_latch = 1'b0, p_wr_n = 1'b1;
    int          w_load = 0, w_latch = 0, w_wr = 0;

    task automatic on_rise(input logic [1:0] kind);
        if (ev_n < 256) ev[ev_n] = {kind, pin_mode, pin_bsel, pin_bus};
        ev_n++;
        chk({pin_mode, pin_bsel, pin_bus} == {p_mode, p_bsel, p_bus},
            "R7 lines settled before strobe", {pin_mode, pin_bsel, pin_bus},
            {p_mode, p_bsel, p_bus});
    endtask

    task automatic on_fall(input int width);
        chk(width == PW, "R7 strobe width", width, PW);
        chk({pin_mode, pin_bsel, pin_bus} == {p_mode, p_bsel, p_bus},
            "R7 lines held after strobe", {pin_mode, pin_bsel, pin_bus},
            {p_mode, p_bsel, p_bus});
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (pin_load && !p_load) begin
                on_rise(2'd1);
                if (pin_mode == 2'b10) chk(rdy_m, "R8 command load while ready", rdy_m, 1);
            end
            if (pin_latch && !p_latch) on_rise(2'd2);
            if (!pin_wr_n && p_wr_n) on_rise(2'd3);
            if (pin_load) w_load++;
            if (pin_latch) w_latch++;
            if (!pin_wr_n) w_wr++;
            if (!pin_load && p_load) begin on_fall(w_load); w_load = 0; end
            if (!pin_latch && p_latch) begin on_fall(w_latch); w_latch = 0; end
            if (pin_wr_n && !p_wr_n) begin on_fall(w_wr); w_wr = 0; end
        end
        p_mode = pin_mode; p_bsel = pin_bsel; p_bus = pin_bus;
        p_load = pin_load; p_latch = pin_latch; p_wr_n = pin_wr_n;
    end

    // expected event list
    logic [12:0] xp [256];
    int          xp_n = 0;

    task automatic push(input logic [1:0] k, input logic [1:0] m,
                        input logic b, input logic [7:0] d);
        if (xp_n < 256) xp[xp_n] = {k, m, b, d};
        xp_n++;
    endtask

    function automatic logic [15:0] wd(input logic [15:0] seed, input int i);
        return seed + 16'(i) * 16'h1F3D;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic wait_busy(input string req);
        bit got = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (busy) begin got = 1'b1; break; end
        end
        chk(got, req, got, 1);
    endtask

    task automatic send_word(input logic [15:0] d, input logic last);
        word_data  = d;
        word_last  = last;
        word_valid = 1'b1;
        while (!word_ready) @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
        word_last  = 1'b0;
    endtask

    task automatic run_op(input logic er, input logic both, input logic [11:0] pg,
                          input int nw, input logic [15:0] seed, input int gap);
        logic [15:0] a;
        bit got;
        xp_n = 0;
        if (er) begin
            push(2'd1, 2'b10, 1'b0, 8'h80);   // R2 erase command load
            push(2'd3, 2'b10, 1'b0, 8'h80);   // R2 write pulse
        end else begin
            push(2'd1, 2'b10, 1'b0, 8'h10);   // R3 page command load
            a = 16'h0;
            for (int i = 0; i < nw; i++) begin
                a = {pg, 4'(i)};             // R5 address join
                push(2'd1, 2'b00, 1'b0, a[7:0]);
                push(2'd1, 2'b01, 1'b0, wd(seed, i) >> 0 & 16'h00FF);
                push(2'd1, 2'b01, 1'b1, wd(seed, i) >> 8);
                push(2'd2, 2'b01, 1'b1, wd(seed, i) >> 8);   // R4 latch
            end
            push(2'd1, 2'b00, 1'b1, a[15:8]);
            push(2'd3, 2'b00, 1'b1, a[15:8]);
        end
        ev_n = 0;
        @(negedge clk);
        erase_req = er | both;
        write_req = ~er | both;
        page_num  = pg;
        wait_busy("R12 busy after accept");
        erase_req = 1'b0;
        write_req = 1'b0;
        chk(tmo_err == 1'b0, "R10 error cleared at accept", tmo_err, 0);
        if (!er) begin
            for (int i = 0; i < nw; i++) begin
                for (int g = 0; g < gap; g++) @(negedge clk);
                send_word(wd(seed, i), (i == nw - 1) && (nw < WPP));
            end
        end
        got = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, "R12 done pulse seen", got, 1);
        chk(busy == 1'b0, "R12 busy low with done", busy, 0);
        chk(tmo_err == 1'b0, "R10 no error on normal busy time", tmo_err, 0);
        @(negedge clk);
        chk(done == 1'b0, "R12 done lasts one clock", done, 0);
        chk(word_ready == 1'b0, "R6 R11 no further word taken", word_ready, 0);
        chk(ev_n == xp_n, "R2 R3 R4 R6 event count", ev_n, xp_n);
        for (int i = 0; i < xp_n && i < ev_n && i < 256; i++)
            chk(ev[i] == xp[i], er ? "R2 R9 erase step" : "R3 R4 R5 page step",
                32'(ev[i]), 32'(xp[i]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({pin_mode, pin_bsel, pin_bus, pin_load, pin_latch, pin_wr_n,
             busy, done, tmo_err, word_ready} == {2'b00, 1'b0, 8'h00, 3'b001, 4'b0000},
            "R1 reset state",
            {pin_mode, pin_bsel, pin_bus, pin_load, pin_latch, pin_wr_n,
             busy, done, tmo_err, word_ready},
            {2'b00, 1'b0, 8'h00, 3'b001, 4'b0000});

        for (int v = 0; v < 6; v++) begin
            run_op(VEC[v][39], VEC[v][38], VEC[v][37:26], int'(VEC[v][25:21]),
                   VEC[v][20:5], int'(VEC[v][4:1]));
            repeat (3) @(negedge clk);
        end

        // R8: requests while the target is busy are ignored
        begin
            bit saw_busy = 1'b0;
            hold_low = 1'b1;
            repeat (3) @(negedge clk);
            ev_n = 0;
            erase_req = 1'b1;
            write_req = 1'b1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (busy) saw_busy = 1'b1;
            end
            erase_req = 1'b0;
            write_req = 1'b0;
            @(negedge clk);
            chk(saw_busy == 1'b0, "R8 no accept while target busy", saw_busy, 0);
            chk(ev_n == 0, "R8 no strobe while target busy", ev_n, 0);
            hold_low = 1'b0;
            repeat (BUSY_N + 4) @(negedge clk);
        end

        // R10: target never recovers after the write pulse
        begin
            bit saw_done = 1'b0;
            bit got = 1'b0;
            int cyc = 0;
            ev_n = 0;
            @(negedge clk);
            erase_req = 1'b1;
            wait_busy("R10 erase accepted");
            erase_req = 1'b0;
            for (int k = 0; k < 50 && pin_wr_n; k++) @(negedge clk);
            hold_low = 1'b1;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                cyc++;
                if (done) saw_done = 1'b1;
                if (tmo_err) begin got = 1'b1; break; end
            end
            chk(got, "R10 timeout flag raised", got, 1);
            chk(cyc >= TMO, "R10 timeout not early", cyc, TMO);
            chk(busy == 1'b0, "R10 idle after timeout", busy, 0);
            chk(saw_done == 1'b0, "R10 no done on timeout", saw_done, 0);
            hold_low = 1'b0;
            repeat (BUSY_N + 10) @(negedge clk);
            chk(tmo_err == 1'b1, "R10 flag stays until next accept", tmo_err, 1);
            run_op(1'b1, 1'b0, 12'h000, 0, 16'h0, 0);
        end

        summary();
        $finish;
    end
endmodule